// File: doc/BRIEF.md
# Windowed Register File

This block is a register file for a processor core whose instructions name 32 architectural registers, while the storage behind them is a larger physical array. Registers 0 to 7 are global: every procedure sees the same eight entries, and register 0 always reads as zero. Registers 8 to 31 are the procedure's private view. They are grouped as outgoing (8-15), local (16-23) and incoming (24-31) registers, and they are reached through a current-window pointer.

A save command moves the pointer to a fresh window for a called procedure. A restore command moves it back. Adjacent windows overlap, so the caller's outgoing registers become the callee's incoming registers without any copying. Two combinational read ports and one write port serve the datapath. When the window set is full, a save is refused and flagged. When only one window is live, a restore is refused and flagged. Spilling refused windows to memory is left to software.

Top module: `windowed_regfile`

## Requirements
- R1: Architectural registers 0 to 7 map to physical entries 0 to 7 in every window, so a value written to a global in one window reads back unchanged in all other windows.
- R2: A read of register 0 on either port returns zero at all times. A write addressed to register 0 changes no register.
- R3: For an architectural register r of 8 or more in window w, the physical entry is 8 + ((16*w + r - 8) mod 128). As a result, registers 24-31 of window w are the same storage as registers 8-15 of window (w+1) mod 8.
- R4: After reset the window pointer is 0, exactly one window is in use, every register reads zero, and both flags are low.
- R5: A save alone, with fewer than 7 windows in use, decrements the window pointer modulo 8 at the next clock edge.
- R6: A save alone, with 7 windows in use, leaves the pointer unchanged and drives the overflow flag high for the one cycle after that edge.
- R7: A restore alone, with more than one window in use, increments the window pointer modulo 8 at the next clock edge (7 wraps to 0).
- R8: A restore alone, with one window in use, leaves the pointer unchanged and drives the underflow flag high for the one cycle after that edge.
- R9: A save and a restore asserted in the same cycle are ignored: the pointer, the window count and both flags stay as if neither had been asserted.
- R10: Reads are combinational. A write in the same cycle to the physical entry being read is presented on that read port in that cycle.
- R11: A write issued in the same cycle as a save or restore lands in the window that was current before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rdAddrA | input | 5 | Architectural register for read port A |
| rdDataA | output | 32 | Read data, port A (combinational) |
| rdAddrB | input | 5 | Architectural register for read port B |
| rdDataB | output | 32 | Read data, port B (combinational) |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Architectural register to write |
| wrData | input | 32 | Write data |
| saveReq | input | 1 | Move to a new window (decrement pointer) |
| restoreReq | input | 1 | Return to the previous window (increment pointer) |
| curWin | output | 3 | Current window pointer |
| overflowFlag | output | 1 | One-cycle pulse after a refused save |
| underflowFlag | output | 1 | One-cycle pulse after a refused restore |

## Verification
The bench fills every register of every window while descending through seven saves to the overflow point, then reads all 32 registers back on the way up to the underflow point. A wrong mapping, a missing overlap or a global that moves with the window shows up there as a value read from the wrong entry. Pointer wrap from 0 to 7 and back, a refused save or restore that still moves the pointer or drops its flag, and simultaneous save and restore are each driven directly. Two further cases are targeted: a write in the same cycle as a save, which lands in the next window if the write path sees the updated pointer, and a read of an entry being written, which returns stale data if forwarding is absent.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  // Strobes the control module hands to the datapath each cycle.
  typedef struct packed {
    logic wrCommit;  // qualified write: enabled and not to register 0
    logic zeroA;     // port A addresses register 0
    logic zeroB;     // port B addresses register 0
  } dpStrobe_t;
endpackage

// File: rtl/rwf_ctrl.sv
module rwf_ctrl
  import rwf_pkg::*;
#(
  parameter int NUM_GLOBAL = 8,
  parameter int NUM_WIN    = 8,
  localparam int ARCH_W    = $clog2(4 * NUM_GLOBAL),
  localparam int CWP_W     = $clog2(NUM_WIN),
  localparam int DEP_W     = $clog2(NUM_WIN) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              saveReq,
  input  logic              restoreReq,
  input  logic              wrEn,
  input  logic [ARCH_W-1:0] wrAddr,
  input  logic [ARCH_W-1:0] rdAddrA,
  input  logic [ARCH_W-1:0] rdAddrB,
  output logic [CWP_W-1:0]  cwp,
  output logic              overflowFlag,
  output logic              underflowFlag,
  output dpStrobe_t         strobe
);

  localparam logic [DEP_W-1:0] MAX_LIVE = DEP_W'(NUM_WIN - 1);
  localparam logic [DEP_W-1:0] MIN_LIVE = DEP_W'(1);

  logic [DEP_W-1:0] liveWins;
  logic doSave, doRestore, canSave, canRestore;

  assign doSave     = saveReq & ~restoreReq;
  assign doRestore  = restoreReq & ~saveReq;
  assign canSave    = (liveWins < MAX_LIVE);
  assign canRestore = (liveWins > MIN_LIVE);

  always_comb begin
    strobe.wrCommit = wrEn && (wrAddr != '0);
    strobe.zeroA    = (rdAddrA == '0);
    strobe.zeroB    = (rdAddrB == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cwp           <= '0;
      liveWins      <= MIN_LIVE;
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
    end else begin
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
      if (doSave) begin
        if (canSave) begin
          cwp      <= cwp - CWP_W'(1);
          liveWins <= liveWins + DEP_W'(1);
        end else begin
          overflowFlag <= 1'b1;
        end
      end else if (doRestore) begin
        if (canRestore) begin
          cwp      <= cwp + CWP_W'(1);
          liveWins <= liveWins - DEP_W'(1);
        end else begin
          underflowFlag <= 1'b1;
        end
      end
    end
  end

  assert_save_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (doSave && canSave) |=> (cwp == $past(cwp) - CWP_W'(1)));

  assert_no_overflow_move_R6: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |-> (cwp == $past(cwp)));

  assert_restore_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (doRestore && canRestore) |=> (cwp == $past(cwp) + CWP_W'(1)));

  assert_no_underflow_move_R8: assert property (@(posedge clk) disable iff (!rstN)
    underflowFlag |-> (cwp == $past(cwp)));

  assert_both_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (saveReq && restoreReq) |=> ($stable(cwp) && !overflowFlag && !underflowFlag));

  assert_live_bounds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (liveWins >= MIN_LIVE) && (liveWins <= MAX_LIVE));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({overflowFlag, underflowFlag}));

endmodule

// File: rtl/rwf_datapath.sv
module rwf_datapath
  import rwf_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NUM_GLOBAL = 8,
  parameter int NUM_WIN    = 8,
  localparam int ARCH_W    = $clog2(4 * NUM_GLOBAL),
  localparam int CWP_W     = $clog2(NUM_WIN),
  localparam int WIN_STEP  = 2 * NUM_GLOBAL,
  localparam int RING      = NUM_WIN * WIN_STEP,
  localparam int PHYS      = NUM_GLOBAL + RING,
  localparam int PHYS_W    = $clog2(PHYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CWP_W-1:0]  cwp,
  input  logic [ARCH_W-1:0] rdAddrA,
  input  logic [ARCH_W-1:0] rdAddrB,
  input  logic [ARCH_W-1:0] wrAddr,
  input  logic [XLEN-1:0]   wrData,
  output logic [XLEN-1:0]   rdDataA,
  output logic [XLEN-1:0]   rdDataB
);

  logic [XLEN-1:0] regs [PHYS];

  // Architectural-to-physical translation through the window pointer.
  function automatic logic [PHYS_W-1:0] toPhys(input logic [CWP_W-1:0] win,
                                               input logic [ARCH_W-1:0] arch);
    int ofs;
    if (int'(arch) < NUM_GLOBAL) return PHYS_W'(arch);
    ofs = (int'(win) * WIN_STEP + int'(arch) - NUM_GLOBAL) % RING;
    return PHYS_W'(NUM_GLOBAL + ofs);
  endfunction

  logic [PHYS_W-1:0] idxA, idxB, idxW;
  assign idxA = toPhys(cwp, rdAddrA);
  assign idxB = toPhys(cwp, rdAddrB);
  assign idxW = toPhys(cwp, wrAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PHYS; i++) regs[i] <= '0;
    end else if (strobe.wrCommit) begin
      regs[idxW] <= wrData;
    end
  end

  always_comb begin
    if (strobe.zeroA)                             rdDataA = '0;
    else if (strobe.wrCommit && (idxW == idxA))   rdDataA = wrData;
    else                                          rdDataA = regs[idxA];
    if (strobe.zeroB)                             rdDataB = '0;
    else if (strobe.wrCommit && (idxW == idxB))   rdDataB = wrData;
    else                                          rdDataB = regs[idxB];
  end

  assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCommit |=> (regs[$past(idxW)] == $past(wrData)));

  assert_zero_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    regs[0] == '0);

  assert_globals_fixed_R1: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rdAddrA) < NUM_GLOBAL) |-> (idxA == PHYS_W'(rdAddrA)));

endmodule

// File: rtl/windowed_regfile.sv
module windowed_regfile
  import rwf_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NUM_GLOBAL = 8,
  parameter int NUM_WIN    = 8,
  localparam int ARCH_W    = $clog2(4 * NUM_GLOBAL),
  localparam int CWP_W     = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ARCH_W-1:0] rdAddrA,
  output logic [XLEN-1:0]   rdDataA,
  input  logic [ARCH_W-1:0] rdAddrB,
  output logic [XLEN-1:0]   rdDataB,
  input  logic              wrEn,
  input  logic [ARCH_W-1:0] wrAddr,
  input  logic [XLEN-1:0]   wrData,
  input  logic              saveReq,
  input  logic              restoreReq,
  output logic [CWP_W-1:0]  curWin,
  output logic              overflowFlag,
  output logic              underflowFlag
);

  dpStrobe_t strobe;

  rwf_ctrl #(.NUM_GLOBAL(NUM_GLOBAL), .NUM_WIN(NUM_WIN)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .saveReq(saveReq), .restoreReq(restoreReq),
    .wrEn(wrEn), .wrAddr(wrAddr),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .cwp(curWin),
    .overflowFlag(overflowFlag), .underflowFlag(underflowFlag),
    .strobe(strobe)
  );

  rwf_datapath #(.XLEN(XLEN), .NUM_GLOBAL(NUM_GLOBAL), .NUM_WIN(NUM_WIN)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .cwp(curWin),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .wrAddr(wrAddr), .wrData(wrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

endmodule

// File: tb/sim_windowed_regfile.sv
module sim_windowed_regfile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0;
  logic        wrEn = 1'b0, saveReq = 1'b0, restoreReq = 1'b0;
  logic [2:0]  curWin;
  logic        overflowFlag, underflowFlag;

  always #5 clk = ~clk;

  windowed_regfile u0 (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .saveReq(saveReq), .restoreReq(restoreReq),
    .curWin(curWin), .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
  );

  int errors = 0;
  int checks = 0;

  // Bench model built from R1..R8.
  logic [31:0] mdl [136];
  int mCwp = 0, mLive = 1;
  bit mOvf = 0, mUdf = 0;

  function automatic int ph(int w, int r);
    if (r < 8) return r;
    return 8 + ((16 * w + r - 8) % 128);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock cycle with the given command; model updated at the edge.
  task automatic cyc(bit sv, bit rs, bit we, int wa, logic [31:0] wd);
    saveReq = sv; restoreReq = rs; wrEn = we; wrAddr = 5'(wa); wrData = wd;
    @(posedge clk);
    if (we && wa != 0) mdl[ph(mCwp, wa)] = wd;
    mOvf = 0; mUdf = 0;
    if (sv && !rs) begin
      if (mLive < 7) begin mCwp = (mCwp + 7) % 8; mLive++; end
      else mOvf = 1;
    end else if (rs && !sv) begin
      if (mLive > 1) begin mCwp = (mCwp + 1) % 8; mLive--; end
      else mUdf = 1;
    end
    @(negedge clk);
    saveReq = 0; restoreReq = 0; wrEn = 0; wrAddr = '0; wrData = '0;
  endtask

  task automatic chkState(string tag);
    chk({tag, " curWin"}, 32'(curWin), 32'(mCwp));
    chk({tag, " overflow"}, 32'(overflowFlag), 32'(mOvf));
    chk({tag, " underflow"}, 32'(underflowFlag), 32'(mUdf));
  endtask

  task automatic readAll(string tag);
    for (int r = 0; r < 32; r++) begin
      rdAddrA = 5'(r); rdAddrB = 5'(31 - r);
      #1;
      chk(tag, rdDataA, (r == 0) ? 32'h0 : mdl[ph(mCwp, r)]);
      chk(tag, rdDataB, (r == 31) ? 32'h0 : mdl[ph(mCwp, 31 - r)]);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 136; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R4: reset state
    chkState("R4 reset");
    readAll("R4 reset read");

    // R2: write to register 0 is discarded; globals written in window 0
    cyc(0, 0, 1, 0, 32'hDEAD_BEEF);
    rdAddrA = 0; #1; chk("R2 r0 after write", rdDataA, 32'h0);
    for (int g = 1; g < 8; g++) cyc(0, 0, 1, g, 32'h6100_0000 + 32'(g));

    // R3/R1/R5/R6: descend, filling each window, until a save is refused
    for (int s = 0; s < 7; s++) begin
      for (int r = 8; r < 32; r++)
        cyc(0, 0, 1, r, {8'hA5, 8'(mCwp), 8'(s), 8'(r)});
      readAll("R3 window fill");
      readAll("R1 globals");
      cyc(1, 0, 0, 0, 32'h0);
      chkState(mOvf ? "R6 save refused" : "R5 save");
    end

    // R9: save and restore together
    cyc(1, 1, 0, 0, 32'h0);
    chkState("R9 both at full");

    // R3/R7/R8: ascend, reading back, until a restore is refused
    for (int s = 0; s < 7; s++) begin
      readAll("R3 window readback");
      cyc(0, 1, 0, 0, 32'h0);
      chkState(mUdf ? "R8 restore refused" : "R7 restore");
    end
    cyc(1, 1, 0, 0, 32'h0);
    chkState("R9 both at empty");

    // R11: write in the same cycle as a save lands in the old window
    cyc(1, 0, 1, 20, 32'h1111_2020);
    chkState("R5 save wraps 0 to 7");
    rdAddrA = 20; #1; chk("R11 new window untouched", rdDataA, mdl[ph(mCwp, 20)]);
    cyc(0, 1, 1, 17, 32'h7777_1717);
    chkState("R7 restore wraps 7 to 0");
    rdAddrA = 20; #1; chk("R11 save-cycle write", rdDataA, 32'h1111_2020);
    cyc(1, 0, 0, 0, 32'h0);
    rdAddrA = 17; #1; chk("R11 restore-cycle write", rdDataA, 32'h7777_1717);
    cyc(0, 1, 0, 0, 32'h0);

    // R10: same-cycle write forwarded to the read port
    rdAddrA = 9; rdAddrB = 0;
    wrEn = 1; wrAddr = 9; wrData = 32'hF0F0_0909;
    #1;
    chk("R10 forward port A", rdDataA, 32'hF0F0_0909);
    chk("R10 other port unaffected", rdDataB, 32'h0);
    wrEn = 0;
    rdAddrB = 9; wrEn = 1; wrAddr = 0; wrData = 32'h1234_5678;
    #1;
    chk("R2 r0 write not forwarded", rdDataB, mdl[ph(mCwp, 9)]);
    wrEn = 0; wrAddr = 0;
    cyc(0, 0, 1, 9, 32'hF0F0_0909);
    rdAddrA = 9; #1; chk("R10 written value held", rdDataA, 32'hF0F0_0909);
    readAll("R1 final");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule